// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block sits between an interrupt source layer and a single processor. It keeps one 32-bit presentation word, plus two more values: the priority of whatever is pending and a request priority for inter-processor interrupts (IPIs). The presentation word carries the processor's current priority in its top byte and the pending source number in its low 24 bits. The block drives one interrupt line to the processor. Priorities run from most favoured (0x00) to least favoured (0xFF).

The source layer offers an interrupt as a source number with a priority. The block answers in the same cycle with accept or reject. An accepted offer that beats the pending one displaces it, and the displaced source is handed back on a reject strobe. The processor side has five register operations: set current priority, set IPI priority, accept (a read with side effects), poll (a plain read) and end-of-interrupt. End-of-interrupt is forwarded to the sources on an EOI strobe. When the processor becomes more willing to take interrupts and nothing is pending, a resend strobe asks every source to offer again. An IPI uses the same presentation slot as external sources, under the fixed source number 2.

Top module: `irq_presenter`

## Requirements
- R1: `rd_data` is the presentation word: bits 31:24 hold the current processor priority and bits 23:0 the pending source number. A value of zero in bits 23:0 means nothing is pending. `irq_out` is high only while bits 23:0 are non-zero.
- R2: An offer is answered in its own cycle with exactly one of `offer_accept` or `offer_reject`. It is rejected when its priority is greater than or equal to the current priority, or when a pending interrupt has a priority less than or equal to the offered one.
- R3: An accepted offer loads its source number into bits 23:0 and raises `irq_out` after the next clock edge. It records its priority as the pending priority. If the interrupt it displaces came from an external source, one clock later `reject_pulse` pulses with `reject_src` set to the displaced number.
- R4: Op code 3 (accept) leaves the whole word on `rd_data` during its cycle. After the edge, `irq_out` is low, bits 31:24 hold the former pending priority, bits 23:0 are zero and the pending priority is 0xFF.
- R5: Op code 4 (poll) changes nothing. `rd_mfrr` always shows the IPI request priority.
- R6: Op code 2 writes the IPI request priority from `op_wdata[7:0]`. If the new value is below the current priority and no pending interrupt has a priority less than or equal to it, an IPI is presented: bits 23:0 become 2, the pending priority becomes the new value, `irq_out` rises, and a pending external source is rejected. A pending IPI is never rejected this way.
- R7: Op code 1 writes the current priority from `op_wdata[7:0]`. If the new value is more favoured than the old one and an interrupt is pending whose priority is numerically greater than or equal to the new value, the pending number is cleared, `irq_out` falls and an external owner is rejected.
- R8: A current-priority write of an equal or less favoured value while nothing is pending performs a resend. The resend first presents an IPI if the IPI request priority is below the new current priority, then pulses `resend_pulse`.
- R9: Op code 5 (end-of-interrupt) sets the current priority from `op_wdata[31:24]` and pulses `eoi_pulse` with `eoi_src` = `op_wdata[23:0]`. If nothing is pending, a resend as in R8 follows.
- R10: Reset makes the word zero, the pending priority and the IPI request priority 0xFF, `irq_out` low and all strobes low.
- R11: An offer made in a cycle that also carries a register operation (`op_valid` high) is rejected and leaves no trace in the state.
- R12: The reject, EOI and resend strobes are registered. Each one is high for exactly the one cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| offer_valid | input | 1 | Source layer offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_accept | output | 1 | Offer taken (combinational) |
| offer_reject | output | 1 | Offer refused (combinational) |
| op_valid | input | 1 | Register operation this cycle |
| op_code | input | 3 | 1 set priority, 2 set IPI priority, 3 accept, 4 poll, 5 EOI |
| op_wdata | input | 32 | Operation write data |
| rd_data | output | 32 | Presentation word |
| rd_mfrr | output | 8 | IPI request priority |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_pulse | output | 1 | Strobe returning a displaced source |
| reject_src | output | 24 | Number of the displaced source |
| eoi_pulse | output | 1 | End-of-interrupt strobe to the sources |
| eoi_src | output | 24 | Source number being completed |
| resend_pulse | output | 1 | Request for all sources to offer again |

## Verification
An offer from the source layer and a processor register operation can arrive in the same cycle. The bench provokes this by driving an IPI-priority write together with an offer whose priority would otherwise win. It judges the result in two ways: the offer must be refused in that cycle, and in the next cycle the word and the line must show only the effect of the register write. The bench then makes the same offer alone and expects it to be accepted, which shows the earlier refusal came from the collision and not from priority.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    parameter int SRC_W  = 24;
    parameter int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SET_CPPR = 3'd1,
        OP_SET_MFRR = 3'd2,
        OP_ACCEPT   = 3'd3,
        OP_POLL     = 3'd4,
        OP_EOI      = 3'd5
    } op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xisr;
        logic [PRIO_W-1:0] pend;
        logic [PRIO_W-1:0] mfrr;
        logic              ext;
        logic              irq;
        logic              rej;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
    } state_t;
endpackage

// File: rtl/irqp_offer_judge.sv
module irqp_offer_judge
    import irqp_pkg::*;
(
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pend,
    output logic              take
);
    // Take when strictly better than the processor and than anything pending.
    always_comb begin
        take = (prio < cppr) && !(busy && (pend <= prio));
    end
endmodule

// File: rtl/irqp_ipi_judge.sv
module irqp_ipi_judge
    import irqp_pkg::*;
(
    input  logic [PRIO_W-1:0] mfrr,
    input  logic [PRIO_W-1:0] cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pend,
    output logic              present
);
    // IPI request below the processor priority and not beaten by the pending one.
    always_comb begin
        present = (mfrr < cppr) && !(busy && (pend <= mfrr));
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              offer_accept,
    output logic              offer_reject,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic [PRIO_W-1:0] rd_mfrr,
    output logic              irq_out,
    output logic              reject_pulse,
    output logic [SRC_W-1:0]  reject_src,
    output logic              eoi_pulse,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_pulse
);
    state_t st_q, st_d;

    logic              busy_q;
    logic [PRIO_W-1:0] new_cppr;
    logic [PRIO_W-1:0] new_mfrr;
    logic              offer_take;
    logic              ipi_on_mfrr;
    logic              ipi_on_resend;
    op_e               op;

    assign op       = op_e'(op_code);
    assign busy_q   = (st_q.xisr != '0);
    assign new_cppr = (op == OP_EOI) ? op_wdata[WORD_W-1:SRC_W] : op_wdata[PRIO_W-1:0];
    assign new_mfrr = op_wdata[PRIO_W-1:0];

    irqp_offer_judge u_offer (
        .prio (offer_prio),
        .cppr (st_q.cppr),
        .busy (busy_q),
        .pend (st_q.pend),
        .take (offer_take)
    );

    irqp_ipi_judge u_ipi_write (
        .mfrr    (new_mfrr),
        .cppr    (st_q.cppr),
        .busy    (busy_q),
        .pend    (st_q.pend),
        .present (ipi_on_mfrr)
    );

    // A resend only happens with nothing pending.
    irqp_ipi_judge u_ipi_resend (
        .mfrr    (st_q.mfrr),
        .cppr    (new_cppr),
        .busy    (1'b0),
        .pend    (st_q.pend),
        .present (ipi_on_resend)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rej     = 1'b0;
        st_d.rej_src = '0;
        st_d.eoi     = 1'b0;
        st_d.eoi_src = '0;
        st_d.resend  = 1'b0;
        offer_accept = 1'b0;

        if (op_valid) begin
            case (op)
                OP_SET_CPPR: begin
                    st_d.cppr = new_cppr;
                    if (new_cppr < st_q.cppr) begin
                        if (busy_q && (new_cppr <= st_q.pend)) begin
                            st_d.xisr = '0;
                            st_d.pend = PRIO_NONE;
                            st_d.irq  = 1'b0;
                            st_d.ext  = 1'b0;
                            if (st_q.ext) begin
                                st_d.rej     = 1'b1;
                                st_d.rej_src = st_q.xisr;
                            end
                        end
                    end else if (!busy_q) begin
                        st_d.resend = 1'b1;
                        if (ipi_on_resend) begin
                            st_d.xisr = IPI_SRC;
                            st_d.pend = st_q.mfrr;
                            st_d.ext  = 1'b0;
                            st_d.irq  = 1'b1;
                        end
                    end
                end
                OP_SET_MFRR: begin
                    st_d.mfrr = new_mfrr;
                    if (ipi_on_mfrr) begin
                        if (busy_q && st_q.ext) begin
                            st_d.rej     = 1'b1;
                            st_d.rej_src = st_q.xisr;
                        end
                        st_d.xisr = IPI_SRC;
                        st_d.pend = new_mfrr;
                        st_d.ext  = 1'b0;
                        st_d.irq  = 1'b1;
                    end
                end
                OP_ACCEPT: begin
                    st_d.irq  = 1'b0;
                    st_d.cppr = st_q.pend;
                    st_d.xisr = '0;
                    st_d.pend = PRIO_NONE;
                    st_d.ext  = 1'b0;
                end
                OP_EOI: begin
                    st_d.cppr    = new_cppr;
                    st_d.eoi     = 1'b1;
                    st_d.eoi_src = op_wdata[SRC_W-1:0];
                    if (!busy_q) begin
                        st_d.resend = 1'b1;
                        if (ipi_on_resend) begin
                            st_d.xisr = IPI_SRC;
                            st_d.pend = st_q.mfrr;
                            st_d.ext  = 1'b0;
                            st_d.irq  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (offer_valid && offer_take) begin
            offer_accept = 1'b1;
            if (busy_q && st_q.ext) begin
                st_d.rej     = 1'b1;
                st_d.rej_src = st_q.xisr;
            end
            st_d.xisr = offer_src;
            st_d.pend = offer_prio;
            st_d.ext  = 1'b1;
            st_d.irq  = 1'b1;
        end
        offer_reject = offer_valid && !offer_accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.pend    <= PRIO_NONE;
            st_q.mfrr    <= PRIO_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data      = {st_q.cppr, st_q.xisr};
    assign rd_mfrr      = st_q.mfrr;
    assign irq_out      = st_q.irq;
    assign reject_pulse = st_q.rej;
    assign reject_src   = st_q.rej_src;
    assign eoi_pulse    = st_q.eoi;
    assign eoi_src      = st_q.eoi_src;
    assign resend_pulse = st_q.resend;

    // R1: the line is only high with a number pending
    a_r1_line_needs_number: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (rd_data[SRC_W-1:0] != '0));

    // R2: every offer gets exactly one answer
    a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_accept != offer_reject));

    // R3: a taken offer is presented next cycle
    a_r3_taken_presented: assert property (@(posedge clk) disable iff (!rst_n)
        offer_accept |=> (irq_out && rd_data[SRC_W-1:0] == $past(offer_src)));

    // R4: accept drops the line and empties the slot
    a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |=> (!irq_out && rd_data[SRC_W-1:0] == '0));

    // R5: poll leaves everything visible unchanged
    a_r5_poll_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4) |=> ($stable(rd_data) && $stable(rd_mfrr) && $stable(irq_out)));

    // R9: end-of-interrupt is forwarded with its number
    a_r9_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> (eoi_pulse && eoi_src == $past(op_wdata[SRC_W-1:0])));

    // R11: an offer colliding with a register operation is refused
    a_r11_collision_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && op_valid) |-> offer_reject);

    // R12: a reject strobe always has a cause one cycle earlier
    a_r12_reject_caused: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |-> $past(op_valid || offer_accept));
endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_accept, offer_reject;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_wdata = '0;
    logic [31:0] rd_data;
    logic [7:0]  rd_mfrr;
    logic        irq_out, reject_pulse, eoi_pulse, resend_pulse;
    logic [23:0] reject_src, eoi_src;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    irq_presenter uut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_accept(offer_accept), .offer_reject(offer_reject),
        .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
        .rd_data(rd_data), .rd_mfrr(rd_mfrr), .irq_out(irq_out),
        .reject_pulse(reject_pulse), .reject_src(reject_src),
        .eoi_pulse(eoi_pulse), .eoi_src(eoi_src), .resend_pulse(resend_pulse)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [31:0] wd;
        logic        ov;
        logic [23:0] osrc;
        logic [7:0]  oprio;
        logic        eacc;
        logic [31:0] erd;
        logic        eirq;
        logic        erej;
        logic [23:0] erejsrc;
        logic        ers;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t TBL [NVEC] = '{
        '{4'd2,  3'd0, 32'h0,        1'b1, 24'h10, 8'd5, 1'b0, 32'h00000000, 1'b0, 1'b0, 24'h0,  1'b0}, // R2 prio >= cppr 0
        '{4'd8,  3'd1, 32'hFF,       1'b0, 24'h0,  8'd0, 1'b0, 32'hFF000000, 1'b0, 1'b0, 24'h0,  1'b1}, // R8 resend, no IPI
        '{4'd3,  3'd0, 32'h0,        1'b1, 24'h10, 8'd5, 1'b1, 32'hFF000010, 1'b1, 1'b0, 24'h0,  1'b0}, // R3 taken
        '{4'd2,  3'd0, 32'h0,        1'b1, 24'h20, 8'd5, 1'b0, 32'hFF000010, 1'b1, 1'b0, 24'h0,  1'b0}, // R2 equal to pending
        '{4'd3,  3'd0, 32'h0,        1'b1, 24'h21, 8'd3, 1'b1, 32'hFF000021, 1'b1, 1'b1, 24'h10, 1'b0}, // R3 displace 0x10
        '{4'd5,  3'd4, 32'h0,        1'b0, 24'h0,  8'd0, 1'b0, 32'hFF000021, 1'b1, 1'b0, 24'h0,  1'b0}, // R5 poll
        '{4'd4,  3'd3, 32'h0,        1'b0, 24'h0,  8'd0, 1'b0, 32'h03000000, 1'b0, 1'b0, 24'h0,  1'b0}, // R4 accept
        '{4'd2,  3'd0, 32'h0,        1'b1, 24'h30, 8'd3, 1'b0, 32'h03000000, 1'b0, 1'b0, 24'h0,  1'b0}, // R2 equal to cppr
        '{4'd9,  3'd5, 32'hFF000021, 1'b0, 24'h0,  8'd0, 1'b0, 32'hFF000000, 1'b0, 1'b0, 24'h0,  1'b1}, // R9 eoi + resend
        '{4'd3,  3'd0, 32'h0,        1'b1, 24'h40, 8'd6, 1'b1, 32'hFF000040, 1'b1, 1'b0, 24'h0,  1'b0}, // R3
        '{4'd6,  3'd2, 32'h04,       1'b0, 24'h0,  8'd0, 1'b0, 32'hFF000002, 1'b1, 1'b1, 24'h40, 1'b0}, // R6 IPI displaces 0x40
        '{4'd2,  3'd0, 32'h0,        1'b1, 24'h50, 8'd4, 1'b0, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b0}, // R2 vs IPI
        '{4'd6,  3'd0, 32'h0,        1'b1, 24'h51, 8'd1, 1'b1, 32'hFF000051, 1'b1, 1'b0, 24'h0,  1'b0}, // R6 IPI not rejected
        '{4'd7,  3'd1, 32'h01,       1'b0, 24'h0,  8'd0, 1'b0, 32'h01000000, 1'b0, 1'b1, 24'h51, 1'b0}, // R7 clear + reject
        '{4'd8,  3'd1, 32'h08,       1'b0, 24'h0,  8'd0, 1'b0, 32'h08000002, 1'b1, 1'b0, 24'h0,  1'b1}, // R8 resend raises IPI
        '{4'd6,  3'd2, 32'h06,       1'b0, 24'h0,  8'd0, 1'b0, 32'h08000002, 1'b1, 1'b0, 24'h0,  1'b0}, // R6 beaten, no change
        '{4'd4,  3'd3, 32'h0,        1'b0, 24'h0,  8'd0, 1'b0, 32'h04000000, 1'b0, 1'b0, 24'h0,  1'b0}, // R4
        '{4'd11, 3'd2, 32'hFF,       1'b1, 24'h60, 8'd1, 1'b0, 32'h04000000, 1'b0, 1'b0, 24'h0,  1'b0}, // R11 collision
        '{4'd11, 3'd0, 32'h0,        1'b1, 24'h60, 8'd1, 1'b1, 32'h04000060, 1'b1, 1'b0, 24'h0,  1'b0}, // R11 alone taken
        '{4'd7,  3'd1, 32'h00,       1'b0, 24'h0,  8'd0, 1'b0, 32'h00000000, 1'b0, 1'b1, 24'h60, 1'b0}  // R7
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 1'b0; op_code = '0; op_wdata = '0;
        offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
    endtask

    initial begin
        #(PERIOD*100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(rd_data == 32'h0, "R10 word", rd_data, 32'h0);
        chk(rd_mfrr == 8'hFF, "R10 mfrr", {24'h0, rd_mfrr}, 32'hFF);
        chk(!irq_out && !reject_pulse && !eoi_pulse && !resend_pulse, "R10 outputs",
            {28'h0, irq_out, reject_pulse, eoi_pulse, resend_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            string tg;
            tg = $sformatf("R%0d step%0d", TBL[i].req, i);
            op_valid = (TBL[i].op != 3'd0); op_code = TBL[i].op; op_wdata = TBL[i].wd;
            offer_valid = TBL[i].ov; offer_src = TBL[i].osrc; offer_prio = TBL[i].oprio;
            #1;
            chk(offer_accept == TBL[i].eacc && (offer_reject == (TBL[i].ov && !TBL[i].eacc)),
                {tg, " answer"}, {30'h0, offer_accept, offer_reject}, {30'h0, TBL[i].eacc, TBL[i].ov && !TBL[i].eacc});
            @(negedge clk);
            chk(rd_data == TBL[i].erd, {tg, " word"}, rd_data, TBL[i].erd);
            chk(irq_out == TBL[i].eirq, {tg, " line"}, {31'h0, irq_out}, {31'h0, TBL[i].eirq});
            chk(reject_pulse == TBL[i].erej && (!TBL[i].erej || reject_src == TBL[i].erejsrc),
                {tg, " reject"}, {reject_pulse, 7'h0, reject_src}, {TBL[i].erej, 7'h0, TBL[i].erejsrc});
            chk(resend_pulse == TBL[i].ers, {tg, " resend"}, {31'h0, resend_pulse}, {31'h0, TBL[i].ers});
        end
        idle();

        // R5 rd_mfrr tracks an IPI-priority write (0x33 is not below cppr 0)
        op_valid = 1'b1; op_code = 3'd2; op_wdata = 32'h33;
        @(negedge clk);
        idle();
        chk(rd_mfrr == 8'h33, "R5 mfrr", {24'h0, rd_mfrr}, 32'h33);
        chk(!irq_out, "R6 no IPI above cppr", {31'h0, irq_out}, 32'h0);

        // R9 EOI forwards number, restores priority, resends
        op_valid = 1'b1; op_code = 3'd5; op_wdata = 32'h05000077;
        @(negedge clk);
        idle();
        chk(eoi_pulse && eoi_src == 24'h77, "R9 eoi strobe", {eoi_pulse, 7'h0, eoi_src}, {1'b1, 7'h0, 24'h77});
        chk(resend_pulse, "R9 resend", {31'h0, resend_pulse}, 32'h1);
        chk(rd_data == 32'h05000000, "R9 word", rd_data, 32'h05000000);
        @(negedge clk);
        // R12 strobes last one cycle
        chk(!eoi_pulse && !resend_pulse, "R12 single cycle", {30'h0, eoi_pulse, resend_pulse}, 32'h0);

        // R4 accept returns the word in its own cycle
        offer_valid = 1'b1; offer_src = 24'h88; offer_prio = 8'd2;
        @(negedge clk);
        idle();
        op_valid = 1'b1; op_code = 3'd3;
        #1;
        chk(rd_data == 32'h05000088, "R4 read value", rd_data, 32'h05000088);
        @(negedge clk);
        idle();
        chk(rd_data == 32'h02000000 && !irq_out, "R4 after accept", rd_data, 32'h02000000);

        // R10 reset mid-run after an IPI is up (mfrr 1 < cppr 2)
        op_valid = 1'b1; op_code = 3'd2; op_wdata = 32'h01;
        @(negedge clk);
        idle();
        chk(irq_out && rd_data == 32'h02000002, "R6 IPI up", rd_data, 32'h02000002);
        rst_n = 1'b0;
        #1;
        chk(rd_data == 32'h0 && rd_mfrr == 8'hFF && !irq_out, "R10 reset mid-run",
            {rd_data[31:8], rd_mfrr}, 32'h000000FF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule